// File: doc/BRIEF.md
# Multiply-Accumulate Step Unit

This block runs one step of a pipelined dot-product loop. Each accepted step folds the product held in its product register into a 32-bit accumulator, either by subtracting or adding it. It then sets the zero and negative flags from the new accumulator value. On the same clock edge it reloads both multiplier operands, X and Y, from the read data of two external RAM banks. A third step kind, load, clears the accumulator and forces the flags to "zero" while still reloading the operands. This is how such a loop is primed.

The product register always holds the signed product of the X and Y it sits beside. A step therefore always accumulates the product of the operands loaded by the step before it. The unit issues one read request to each bank, carrying a pointer select and a pointer modifier taken from the step's instruction field. The banks return read data in the same cycle, and the unit captures it at the clock edge. The banks and the pointer registers are outside this block.

Top module: `mac_step_unit`

## Requirements
- R1: After reset, x_q, y_q, prod_q, acc_q and flags_q are all zero.
- R2: A subtract step (step_kind 2'b00) sets acc_q to acc_q − prod_q, using the values from before the edge and wrapping modulo 2^32.
- R3: An accumulate step (step_kind 2'b01) sets acc_q to acc_q + prod_q, using the values from before the edge and wrapping modulo 2^32.
- R4: A load step (step_kind 2'b10) sets acc_q to zero and flags_q to 4'b0010, which is the zero flag alone.
- R5: After a subtract or accumulate step, flags_q[1] (zero) is 1 exactly when the new acc_q is zero, and flags_q[3] (negative) equals bit 31 of the new acc_q. flags_q[2] and flags_q[0] keep their values.
- R6: An accepted step loads x_q from bank0_rdata. During that step, rd0_req is 1, rd0_ptr equals step_field[1:0] and rd0_mod equals step_field[3:2].
- R7: An accepted step loads y_q from bank1_rdata. During that step, rd1_req is 1, rd1_ptr equals step_field[5:4] and rd1_mod equals step_field[7:6].
- R8: After every clock edge, prod_q equals the signed 16×16 product of x_q and y_q, sign-extended to 32 bits.
- R9: A step is accepted only when step_field[8] is 0 and step_kind is not 2'b11. If it is not accepted, both read requests stay low and no register changes.
- R10: While step_en is low, no register changes and both read requests stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Step request this cycle |
| step_kind | input | 2 | 00 subtract, 01 accumulate, 10 load, 11 reserved |
| step_field | input | 9 | Operand field: [1:0]/[3:2] bank 0 pointer/modifier, [5:4]/[7:6] bank 1 pointer/modifier, [8] must be 0 |
| bank0_rdata | input | 16 | Read data from bank 0 for the X operand |
| bank1_rdata | input | 16 | Read data from bank 1 for the Y operand |
| x_q | output | 16 | X multiplier operand |
| y_q | output | 16 | Y multiplier operand |
| prod_q | output | 32 | Signed product of X and Y |
| acc_q | output | 32 | Accumulator |
| flags_q | output | 4 | Status nibble: [3] negative, [1] zero, [2] and [0] spare |
| rd0_req | output | 1 | Bank 0 read request |
| rd0_ptr | output | 2 | Bank 0 pointer select |
| rd0_mod | output | 2 | Bank 0 pointer modifier |
| rd1_req | output | 1 | Bank 1 read request |
| rd1_ptr | output | 2 | Bank 1 pointer select |
| rd1_mod | output | 2 | Bank 1 pointer modifier |

## Verification
The bench checks that each step uses the product of the previous operands. A design that multiplied the freshly read data into the accumulator would be off by one element of the dot product. It drives the most negative operand squared, and a mixed-sign product at full scale. An unsigned multiplier, or one that keeps only 16 bits, would give a visibly wrong product or sum. Accumulate and subtract steps that wrap the accumulator through zero show whether the zero and negative flags come from all 32 bits. Steps with the reserved kind, with field bit 8 set, or with no enable must leave every register untouched and raise no request; a unit that decoded them loosely would corrupt X, Y or the sum.

// File: rtl/mac_step_pkg.sv
package mac_step_pkg;
   typedef enum logic [1:0] {
      MS_SUB  = 2'b00,
      MS_ADD  = 2'b01,
      MS_LOAD = 2'b10,
      MS_RSVD = 2'b11
   } mac_kind_e;

   localparam int FLAG_W   = 4;
   localparam int FLAG_NEG = 3;
   localparam int FLAG_ZER = 1;
endpackage

// File: rtl/mac_ptr_decode.sv
module mac_ptr_decode #(
   parameter int PTR_W = 2,
   parameter int MOD_W = 2,
   localparam int FIELD_W = 2 * (PTR_W + MOD_W) + 1
) (
   input  logic               step_en,
   input  logic               kind_ok,
   input  logic [FIELD_W-1:0] field,
   output logic               accept,
   output logic               rd0_req,
   output logic [PTR_W-1:0]   rd0_ptr,
   output logic [MOD_W-1:0]   rd0_mod,
   output logic               rd1_req,
   output logic [PTR_W-1:0]   rd1_ptr,
   output logic [MOD_W-1:0]   rd1_mod
);
   localparam int HALF_W = PTR_W + MOD_W;

   initial begin
      if (PTR_W < 1 || MOD_W < 1) $error("pointer and modifier widths must be positive");
   end

   assign accept  = step_en && kind_ok && !field[FIELD_W-1];
   assign rd0_req = accept;
   assign rd1_req = accept;
   assign rd0_ptr = field[PTR_W-1:0];
   assign rd0_mod = field[HALF_W-1:PTR_W];
   assign rd1_ptr = field[HALF_W+PTR_W-1:HALF_W];
   assign rd1_mod = field[2*HALF_W-1:HALF_W+PTR_W];

   // R9: a step with the reserved field bit set never reaches the banks
   always_comb begin
      if (field[FIELD_W-1]) begin
         p_no_req_on_bad_field_r9: assert (!rd0_req && !rd1_req);
      end
   end
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
   parameter int DATA_W = 16,
   parameter int ACC_W  = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [ACC_W-1:0]  p
);
   localparam int FULL_W = 2 * DATA_W;

   initial begin
      if (ACC_W < FULL_W) $error("accumulator narrower than full product");
   end

   logic signed [FULL_W-1:0] full;
   assign full = $signed(a) * $signed(b);

   generate
      if (ACC_W == FULL_W) begin : g_exact
         assign p = full;
      end else begin : g_extend
         assign p = {{(ACC_W-FULL_W){full[FULL_W-1]}}, full};
      end
   endgenerate
endmodule

// File: rtl/mac_acc_update.sv
module mac_acc_update
   import mac_step_pkg::*;
#(
   parameter int ACC_W = 32
) (
   input  mac_kind_e          kind,
   input  logic [ACC_W-1:0]   acc,
   input  logic [ACC_W-1:0]   prod,
   input  logic [FLAG_W-1:0]  flags,
   output logic [ACC_W-1:0]   acc_nx,
   output logic [FLAG_W-1:0]  flags_nx
);
   initial begin
      if (ACC_W < 2) $error("accumulator too narrow");
   end

   always_comb begin
      acc_nx   = acc;
      flags_nx = flags;
      unique case (kind)
         MS_SUB:  acc_nx = acc - prod;
         MS_ADD:  acc_nx = acc + prod;
         MS_LOAD: acc_nx = '0;
         default: acc_nx = acc;
      endcase
      if (kind == MS_LOAD) begin
         flags_nx           = '0;
         flags_nx[FLAG_ZER] = 1'b1;
      end else if (kind != MS_RSVD) begin
         flags_nx[FLAG_ZER] = (acc_nx == '0);
         flags_nx[FLAG_NEG] = acc_nx[ACC_W-1];
      end
   end
endmodule

// File: rtl/mac_step_unit.sv
module mac_step_unit
   import mac_step_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ACC_W  = 32,
   parameter int PTR_W  = 2,
   parameter int MOD_W  = 2,
   localparam int FIELD_W = 2 * (PTR_W + MOD_W) + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               step_en,
   input  logic [1:0]         step_kind,
   input  logic [FIELD_W-1:0] step_field,
   input  logic [DATA_W-1:0]  bank0_rdata,
   input  logic [DATA_W-1:0]  bank1_rdata,
   output logic [DATA_W-1:0]  x_q,
   output logic [DATA_W-1:0]  y_q,
   output logic [ACC_W-1:0]   prod_q,
   output logic [ACC_W-1:0]   acc_q,
   output logic [FLAG_W-1:0]  flags_q,
   output logic               rd0_req,
   output logic [PTR_W-1:0]   rd0_ptr,
   output logic [MOD_W-1:0]   rd0_mod,
   output logic               rd1_req,
   output logic [PTR_W-1:0]   rd1_ptr,
   output logic [MOD_W-1:0]   rd1_mod
);
   initial begin
      if (ACC_W < 2 * DATA_W) $error("ACC_W must hold a full product");
   end

   mac_kind_e         kind;
   logic              accept;
   logic [ACC_W-1:0]  prod_nx;
   logic [ACC_W-1:0]  acc_nx;
   logic [FLAG_W-1:0] flags_nx;

   assign kind = mac_kind_e'(step_kind);

   mac_ptr_decode #(.PTR_W(PTR_W), .MOD_W(MOD_W)) u_decode (
      .step_en (step_en),
      .kind_ok (kind != MS_RSVD),
      .field   (step_field),
      .accept  (accept),
      .rd0_req (rd0_req),
      .rd0_ptr (rd0_ptr),
      .rd0_mod (rd0_mod),
      .rd1_req (rd1_req),
      .rd1_ptr (rd1_ptr),
      .rd1_mod (rd1_mod)
   );

   mac_mult #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mult (
      .a (bank0_rdata),
      .b (bank1_rdata),
      .p (prod_nx)
   );

   mac_acc_update #(.ACC_W(ACC_W)) u_acc (
      .kind     (kind),
      .acc      (acc_q),
      .prod     (prod_q),
      .flags    (flags_q),
      .acc_nx   (acc_nx),
      .flags_nx (flags_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_q     <= '0;
         y_q     <= '0;
         prod_q  <= '0;
         acc_q   <= '0;
         flags_q <= '0;
      end else if (accept) begin
         x_q     <= bank0_rdata;
         y_q     <= bank1_rdata;
         prod_q  <= prod_nx;
         acc_q   <= acc_nx;
         flags_q <= flags_nx;
      end
   end

   // Independent product of the held operands, for checking only
   logic signed [2*DATA_W-1:0] held_prod;
   assign held_prod = $signed(x_q) * $signed(y_q);

   p_prod_tracks_ops_r8: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> ($signed(prod_q) == held_prod));

   p_sub_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && kind == MS_SUB) |=> acc_q == $past(acc_q) - $past(prod_q));

   p_add_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && kind == MS_ADD) |=> acc_q == $past(acc_q) + $past(prod_q));

   p_load_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && kind == MS_LOAD) |=> (acc_q == '0 && flags_q == 4'b0010));

   p_zero_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (kind == MS_ADD || kind == MS_SUB)) |=>
         (flags_q[FLAG_ZER] == (acc_q == '0)) && (flags_q[FLAG_NEG] == acc_q[ACC_W-1]));

   p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> ($stable(acc_q) && $stable(x_q) && $stable(y_q) && $stable(flags_q)));
endmodule

// File: tb/test_mac_step_unit.sv
module test_mac_step_unit;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        step_en;
   logic [1:0]  step_kind;
   logic [8:0]  step_field;
   logic [15:0] bank0_rdata, bank1_rdata;
   logic [15:0] x_q, y_q;
   logic [31:0] prod_q, acc_q;
   logic [3:0]  flags_q;
   logic        rd0_req, rd1_req;
   logic [1:0]  rd0_ptr, rd0_mod, rd1_ptr, rd1_mod;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   mac_step_unit i_mac_step_unit (
      .clk(clk), .rst_n(rst_n), .step_en(step_en), .step_kind(step_kind),
      .step_field(step_field), .bank0_rdata(bank0_rdata), .bank1_rdata(bank1_rdata),
      .x_q(x_q), .y_q(y_q), .prod_q(prod_q), .acc_q(acc_q), .flags_q(flags_q),
      .rd0_req(rd0_req), .rd0_ptr(rd0_ptr), .rd0_mod(rd0_mod),
      .rd1_req(rd1_req), .rd1_ptr(rd1_ptr), .rd1_mod(rd1_mod)
   );

   typedef struct packed {
      logic [1:0]  kind;
      logic [8:0]  field;
      logic [15:0] d0;
      logic [15:0] d1;
      logic [31:0] acc;
      logic [3:0]  flg;
      logic [31:0] prod;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t TAB [NV] = '{
      '{2'b10, 9'h0E4, 16'h0003, 16'h0004, 32'h00000000, 4'b0010, 32'h0000000C},
      '{2'b01, 9'h01B, 16'hFFFE, 16'h0005, 32'h0000000C, 4'b0000, 32'hFFFFFFF6},
      '{2'b01, 9'h0C6, 16'h0007, 16'h0007, 32'h00000002, 4'b0000, 32'h00000031},
      '{2'b00, 9'h039, 16'h8000, 16'h8000, 32'hFFFFFFD1, 4'b1000, 32'h40000000},
      '{2'b01, 9'h0FF, 16'h7FFF, 16'h8000, 32'h3FFFFFD1, 4'b0000, 32'hC0008000},
      '{2'b00, 9'h000, 16'h0000, 16'h0005, 32'h7FFF7FD1, 4'b0000, 32'h00000000},
      '{2'b01, 9'h055, 16'h0001, 16'h0001, 32'h7FFF7FD1, 4'b0000, 32'h00000001},
      '{2'b10, 9'h0AA, 16'h0010, 16'h0010, 32'h00000000, 4'b0010, 32'h00000100},
      '{2'b00, 9'h012, 16'h0001, 16'hFFFF, 32'hFFFFFF00, 4'b1000, 32'hFFFFFFFF},
      '{2'b01, 9'h021, 16'h0100, 16'h0001, 32'hFFFFFEFF, 4'b1000, 32'h00000100},
      '{2'b01, 9'h08C, 16'h0001, 16'h0001, 32'hFFFFFFFF, 4'b1000, 32'h00000001},
      '{2'b01, 9'h073, 16'h0000, 16'h0000, 32'h00000000, 4'b0010, 32'h00000000}
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   task automatic drive(input logic en, input logic [1:0] k, input logic [8:0] f,
                        input logic [15:0] a, input logic [15:0] b);
      step_en = en; step_kind = k; step_field = f;
      bank0_rdata = a; bank1_rdata = b;
   endtask

   task automatic check_held(input string req, input logic [31:0] acc_e,
                             input logic [15:0] x_e, input logic [15:0] y_e,
                             input logic [3:0] f_e);
      chk(req, "acc", acc_q, acc_e);
      chk(req, "x",   {16'h0, x_q}, {16'h0, x_e});
      chk(req, "y",   {16'h0, y_q}, {16'h0, y_e});
      chk(req, "flags", {28'h0, flags_q}, {28'h0, f_e});
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 5000) begin
         @(posedge clk);
         cyc++;
      end
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [31:0] s_acc;
      logic [15:0] s_x, s_y;
      logic [3:0]  s_f;
      rst_n = 1'b0;
      drive(1'b0, 2'b00, 9'h000, 16'h1234, 16'h5678);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check_held("R1", 32'h0, 16'h0, 16'h0, 4'h0);
      chk("R1", "prod", prod_q, 32'h0);

      // Vector walk: R2 R3 R4 R5 R6 R7 R8
      for (int i = 0; i < NV; i++) begin
         drive(1'b1, TAB[i].kind, TAB[i].field, TAB[i].d0, TAB[i].d1);
         #1;
         chk("R6", "rd0_req", {31'h0, rd0_req}, 32'h1);
         chk("R6", "rd0_ptr", {30'h0, rd0_ptr}, {30'h0, TAB[i].field[1:0]});
         chk("R6", "rd0_mod", {30'h0, rd0_mod}, {30'h0, TAB[i].field[3:2]});
         chk("R7", "rd1_req", {31'h0, rd1_req}, 32'h1);
         chk("R7", "rd1_ptr", {30'h0, rd1_ptr}, {30'h0, TAB[i].field[5:4]});
         chk("R7", "rd1_mod", {30'h0, rd1_mod}, {30'h0, TAB[i].field[7:6]});
         @(negedge clk);
         chk(TAB[i].kind == 2'b10 ? "R4" : (TAB[i].kind == 2'b00 ? "R2" : "R3"),
             "acc", acc_q, TAB[i].acc);
         chk(TAB[i].kind == 2'b10 ? "R4" : "R5", "flags",
             {28'h0, flags_q}, {28'h0, TAB[i].flg});
         chk("R6", "x", {16'h0, x_q}, {16'h0, TAB[i].d0});
         chk("R7", "y", {16'h0, y_q}, {16'h0, TAB[i].d1});
         chk("R8", "prod", prod_q, TAB[i].prod);
      end

      s_acc = acc_q; s_x = x_q; s_y = y_q; s_f = flags_q;

      // R9: field bit 8 set blocks a step
      drive(1'b1, 2'b01, 9'h1FF, 16'hAAAA, 16'h5555);
      #1;
      chk("R9", "rd0_req", {31'h0, rd0_req}, 32'h0);
      chk("R9", "rd1_req", {31'h0, rd1_req}, 32'h0);
      @(negedge clk);
      check_held("R9", s_acc, s_x, s_y, s_f);

      // R9: reserved kind blocks a step
      drive(1'b1, 2'b11, 9'h000, 16'h1111, 16'h2222);
      #1;
      chk("R9", "rd0_req_rsvd", {31'h0, rd0_req}, 32'h0);
      @(negedge clk);
      check_held("R9", s_acc, s_x, s_y, s_f);

      // R10: no enable, all held
      drive(1'b0, 2'b10, 9'h000, 16'h3333, 16'h4444);
      #1;
      chk("R10", "rd1_req", {31'h0, rd1_req}, 32'h0);
      repeat (2) @(negedge clk);
      check_held("R10", s_acc, s_x, s_y, s_f);

      // R3/R5: accumulate a negative product down to a negative sum
      drive(1'b1, 2'b10, 9'h000, 16'hFFFD, 16'h0002);   // load, prod = -6
      @(negedge clk);
      drive(1'b1, 2'b01, 9'h000, 16'h0000, 16'h0000);   // acc = -6
      @(negedge clk);
      chk("R3", "acc_neg", acc_q, 32'hFFFFFFFA);
      chk("R5", "flags_neg", {28'h0, flags_q}, 32'h8);

      // R1: reset mid-run clears again
      drive(1'b1, 2'b01, 9'h000, 16'h0009, 16'h0009);
      @(negedge clk);
      rst_n = 1'b0;
      drive(1'b0, 2'b00, 9'h000, 16'h0, 16'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_held("R1", 32'h0, 16'h0, 16'h0, 4'h0);
      chk("R1", "prod_after_rst", prod_q, 32'h0);

      finish_run();
   end
endmodule